// File: doc/BRIEF.md
# Big-Endian Bus Width Adapter

This block links a 32-bit internal access port to one external memory data bus whose width can be set to 8, 16 or 32 bits. Each internal request is a byte, a word or a longword. Byte ordering is big-endian, so the byte at the lowest address is always the most significant byte of the value. For writes, the block moves each byte of write data onto the external byte lane that matches its address. It also pulls low the active-low strobe for each lane it uses.

When the access is wider than the configured bus, the block runs a series of narrower external cycles in ascending address order. For reads, it collects the returned lanes from every cycle. It then presents one right-justified result and pulses the response one cycle after the final external handshake.

A request whose address does not match its size gets an error response and causes no external activity. Both sides use a valid/ready handshake. The bus width is sampled when each request is accepted.

Top module: `be_bus_adapter`

## Requirements
- R1: Big-endian ordering: for an access of N bytes at address A, the byte at address A+i is bits [(N-1-i)*8+7 : (N-1-i)*8] of the right-justified write or read data.
- R2: `bus_width_i` selects the external width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 behaves as 32 bits. It is sampled when a request is accepted.
- R3: On a 32-bit bus, a byte at address offset 0, 1, 2 or 3 uses lane 3, 2, 1 or 0 respectively. Lane n is `ext_*data[8n+7:8n]` and `ext_strb_no[n]`.
- R4: On a 32-bit bus, a word at offset 0 uses lanes 3 and 2, a word at offset 2 uses lanes 1 and 0, and a longword uses all four lanes.
- R5: On a 16-bit bus, an even-address byte uses lane 1 and an odd-address byte uses lane 0. On an 8-bit bus, every byte uses lane 0.
- R6: An access of N bytes on a bus of W bytes takes max(1, N/W) external cycles. There is no extra cycle, and no cycle is missing.
- R7: Split cycles run in ascending address order. `ext_addr_o` of cycle k equals the request address plus k*min(N,W), so the first cycle carries the most significant part.
- R8: `rsp_valid_o` is high for exactly one cycle, the cycle after the final external handshake. For a read, `rsp_rdata_o` holds the assembled right-justified value with zero upper bits. For a write, it is zero.
- R9: Size codes are 0 byte, 1 word, 2 longword and 3 reserved. A reserved size, a word at an odd address, or a longword whose address bits [1:0] are not zero is answered with `rsp_valid_o` and `rsp_err_o` one cycle after acceptance, and no external cycle.
- R10: Strobes are active-low. Strobes of unused lanes, and all strobes while `ext_valid_o` is low, stay high. Write-data lanes that are not used, and all lanes during a read, are zero.
- R11: A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from acceptance until the response. While `ext_valid_o` is high and `ext_ready_i` is low, address, strobes and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_width_i | input | 2 | External bus width select |
| req_valid_i | input | 1 | Internal request valid |
| req_ready_o | output | 1 | Adapter can accept a request |
| req_write_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 2 | Access size code |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | DW | Right-justified write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Request was rejected as misaligned |
| rsp_rdata_o | output | DW | Right-justified read data |
| ext_valid_o | output | 1 | External cycle request |
| ext_ready_i | input | 1 | External cycle complete |
| ext_write_o | output | 1 | External cycle is a write |
| ext_addr_o | output | AW | Address of the current external cycle |
| ext_strb_no | output | DW/8 | Per-lane strobes, active low |
| ext_wdata_o | output | DW | External write data lanes |
| ext_rdata_i | input | DW | External read data lanes |

## Verification
Two things can happen in the same clock edge. One is the completion of an external cycle, where read lanes are captured and the beat index advances. The other is the lane steering for the next cycle, which comes from that new index. The bench provokes this with zero-wait `ext_ready_i` on split accesses, so consecutive external cycles follow edge to edge. It judges each cycle's address, strobes and data lanes against an independent byte-by-byte model. Randomly inserted wait cycles check the hold rule and the final read assembly under the same mix.

// File: rtl/be_bus_pkg.sv
package be_bus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;

  // log2 of byte count, capped at longword
  function automatic int lg_cap(input logic [1:0] code);
    return (code > 2'd2) ? 2 : int'(code);
  endfunction
endpackage

// File: rtl/be_lane_map.sv
module be_lane_map
  import be_bus_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned NL = DW / 8,
  localparam int unsigned IW = $clog2(NL),
  localparam int unsigned CW = IW + 1
) (
  input  logic [1:0]          size_i,
  input  logic [1:0]          bw_i,
  input  logic [IW-1:0]       addr_lo_i,
  input  logic [IW-1:0]       beat_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [NL-1:0]       lane_en_o,
  output logic [DW-1:0]       lane_wdata_o,
  output logic [NL-1:0][IW-1:0] lane_src_o,
  output logic [CW-1:0]       nbytes_o,
  output logic [CW-1:0]       nbeats_o,
  output logic [1:0]          lg_bb_o
);
  int lg_n, lg_b, lg_bb, nb, busb;

  always_comb begin
    lg_n  = lg_cap(size_i);
    lg_b  = lg_cap(bw_i);
    lg_bb = (lg_n < lg_b) ? lg_n : lg_b;
    nb    = 1 << lg_n;
    busb  = 1 << lg_b;
    lane_en_o    = '0;
    lane_wdata_o = '0;
    lane_src_o   = '0;
    for (int i = 0; i < int'(NL); i++) begin
      int a;
      int ln;
      a  = (int'(addr_lo_i) + i) % int'(NL);
      ln = busb - 1 - (a % busb);
      if (i < nb && (i >> lg_bb) == int'(beat_i)) begin
        lane_en_o[ln]           = 1'b1;
        lane_wdata_o[ln*8 +: 8] = wdata_i[(nb-1-i)*8 +: 8];
        lane_src_o[ln]          = IW'(i);
      end
    end
    nbytes_o = CW'(nb);
    nbeats_o = CW'(nb >> lg_bb);
    lg_bb_o  = 2'(lg_bb);
  end
endmodule

// File: rtl/be_read_gather.sv
module be_read_gather #(
  parameter int unsigned DW = 32,
  localparam int unsigned NL = DW / 8,
  localparam int unsigned IW = $clog2(NL),
  localparam int unsigned CW = IW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cap_i,
  input  logic [NL-1:0]         lane_en_i,
  input  logic [NL-1:0][IW-1:0] lane_src_i,
  input  logic [CW-1:0]         nbytes_i,
  input  logic [DW-1:0]         rdata_i,
  output logic [DW-1:0]         data_o
);
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (clr_i) begin
      data_d = '0;
    end else if (cap_i) begin
      for (int l = 0; l < int'(NL); l++) begin
        if (lane_en_i[l]) begin
          data_d[(int'(nbytes_i) - 1 - int'(lane_src_i[l]))*8 +: 8] = rdata_i[l*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/be_seq_fsm.sv
module be_seq_fsm
  import be_bus_pkg::*;
#(
  parameter int unsigned BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          misalign_i,
  input  logic          ext_ready_i,
  input  logic          last_beat_i,
  output logic          req_ready_o,
  output logic          accept_o,
  output logic          ext_valid_o,
  output logic          beat_done_o,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [BW-1:0] beat_o
);
  seq_state_e    state_q;
  logic [BW-1:0] beat_q;
  logic          err_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign ext_valid_o = (state_q == ST_XFER);
  assign beat_done_o = ext_valid_o && ext_ready_i;
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_err_o   = rsp_valid_o && err_q;
  assign beat_o      = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          beat_q  <= '0;
          err_q   <= misalign_i;
          state_q <= misalign_i ? ST_RESP : ST_XFER;
        end
        ST_XFER: if (ext_ready_i) begin
          if (last_beat_i) state_q <= ST_RESP;
          else             beat_q  <= beat_q + 1'b1;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/be_bus_adapter.sv
module be_bus_adapter
  import be_bus_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      bus_width_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [1:0]      req_size_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rsp_valid_o,
  output logic            rsp_err_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic            ext_valid_o,
  input  logic            ext_ready_i,
  output logic            ext_write_o,
  output logic [AW-1:0]   ext_addr_o,
  output logic [DW/8-1:0] ext_strb_no,
  output logic [DW-1:0]   ext_wdata_o,
  input  logic [DW-1:0]   ext_rdata_i
);
  localparam int unsigned NL = DW / 8;
  localparam int unsigned IW = $clog2(NL);
  localparam int unsigned CW = IW + 1;

  logic                  accept, beat_done, last_beat, misalign;
  logic [IW-1:0]         beat;
  logic                  write_q;
  logic [1:0]            size_q, bw_q;
  logic [AW-1:0]         addr_q;
  logic [DW-1:0]         wdata_q;
  logic [NL-1:0]         lane_en;
  logic [DW-1:0]         lane_wdata;
  logic [NL-1:0][IW-1:0] lane_src;
  logic [CW-1:0]         nbytes, nbeats;
  logic [1:0]            lg_bb;

  assign misalign = (req_size_i == SZ_RSVD)
                 || (req_size_i == SZ_WORD && req_addr_i[0])
                 || (req_size_i == SZ_LONG && |req_addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      size_q  <= '0;
      bw_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      size_q  <= req_size_i;
      bw_q    <= bus_width_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  be_seq_fsm #(.BW(IW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .misalign_i  (misalign),
    .ext_ready_i (ext_ready_i),
    .last_beat_i (last_beat),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .ext_valid_o (ext_valid_o),
    .beat_done_o (beat_done),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .beat_o      (beat)
  );

  be_lane_map #(.DW(DW)) u_map (
    .size_i       (size_q),
    .bw_i         (bw_q),
    .addr_lo_i    (addr_q[IW-1:0]),
    .beat_i       (beat),
    .wdata_i      (wdata_q),
    .lane_en_o    (lane_en),
    .lane_wdata_o (lane_wdata),
    .lane_src_o   (lane_src),
    .nbytes_o     (nbytes),
    .nbeats_o     (nbeats),
    .lg_bb_o      (lg_bb)
  );

  be_read_gather #(.DW(DW)) u_gather (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .cap_i      (beat_done && !write_q),
    .lane_en_i  (lane_en),
    .lane_src_i (lane_src),
    .nbytes_i   (nbytes),
    .rdata_i    (ext_rdata_i),
    .data_o     (rsp_rdata_o)
  );

  assign last_beat   = (CW'(beat) == nbeats - CW'(1));
  assign ext_addr_o  = addr_q + (AW'(beat) << lg_bb);
  assign ext_write_o = ext_valid_o && write_q;
  assign ext_strb_no = ext_valid_o ? ~lane_en : '1;
  assign ext_wdata_o = (ext_valid_o && write_q) ? lane_wdata : '0;
endmodule

// File: rtl/be_bus_adapter_chk.sv
module be_bus_adapter_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      bus_width_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [1:0]      req_size_i,
  input logic [AW-1:0]   req_addr_i,
  input logic            rsp_valid_o,
  input logic            rsp_err_o,
  input logic            ext_valid_o,
  input logic            ext_ready_i,
  input logic [AW-1:0]   ext_addr_o,
  input logic [DW/8-1:0] ext_strb_no,
  input logic [DW-1:0]   ext_wdata_o
);
  logic bad_req;
  assign bad_req = (req_size_i == 2'd3) || (req_size_i == 2'd1 && req_addr_i[0])
                || (req_size_i == 2'd2 && req_addr_i[1:0] != 2'b00);

  // R10
  strb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_valid_o |-> ext_strb_no == '1);

  // R11
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o && !ext_ready_i |=> ext_valid_o && $stable(ext_addr_o)
      && $stable(ext_strb_no) && $stable(ext_wdata_o));

  // R11
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> !req_ready_o);

  // R9
  misalign_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && bad_req |=> rsp_valid_o && rsp_err_o && !ext_valid_o);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R5
  narrow_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o && bus_width_i == 2'd0 |-> ext_strb_no == {{(DW/8-1){1'b1}}, 1'b0});

  // R6
  wide_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o && ext_ready_i && bus_width_i[1] |=> !ext_valid_o);
endmodule

bind be_bus_adapter be_bus_adapter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_width_i (bus_width_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_size_i  (req_size_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .ext_valid_o (ext_valid_o),
  .ext_ready_i (ext_ready_i),
  .ext_addr_o  (ext_addr_o),
  .ext_strb_no (ext_strb_no),
  .ext_wdata_o (ext_wdata_o)
);

// File: tb/be_bus_adapter_tb_top.sv
`timescale 1ns/1ps
module be_bus_adapter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bus_width_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic        ext_valid_o;
  logic        ext_ready_i = 1'b0;
  logic        ext_write_o;
  logic [31:0] ext_addr_o;
  logic [3:0]  ext_strb_no;
  logic [31:0] ext_wdata_o;
  logic [31:0] ext_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  be_bus_adapter dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_bad(input logic [1:0] sz, input logic [31:0] a);
    return sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
  endfunction

  function automatic int bus_bytes(input logic [1:0] bw);
    return bw == 2'd0 ? 1 : (bw == 2'd1 ? 2 : 4);
  endfunction

  // expected lanes of one external cycle, from the byte-address rules
  task automatic exp_beat(input logic [1:0] bw, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input int k, output logic [3:0] strb,
                          output logic [31:0] lanes, output logic [31:0] eaddr);
    int nb = 1 << sz;
    int wb = bus_bytes(bw);
    int bb = nb < wb ? nb : wb;
    strb = 4'hF; lanes = '0; eaddr = a + 32'(k * bb);
    for (int j = 0; j < bb; j++) begin
      int i = k * bb + j;
      int ba = int'(a[1:0]) + i;
      int ln = wb - 1 - (ba % wb);
      strb[ln] = 1'b0;
      lanes[ln*8 +: 8] = wd[(nb-1-i)*8 +: 8];
    end
  endtask

  function automatic string lane_tag(input logic [1:0] bw, input logic [1:0] sz);
    if (bw == 2'd3) return "R2";
    if (bw == 2'd2) return sz == 2'd0 ? "R3" : "R4";
    return "R5";
  endfunction

  task automatic run_access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                            input logic [31:0] wd, input logic [1:0] bw, input bit zero_wait);
    int nb, wb, bb, nbeats;
    logic [31:0] exp_rd = '0;
    logic [3:0]  es;
    logic [31:0] el, ea;
    bus_width_i = bw;
    req_write_i = wr; req_size_i = sz; req_addr_i = a; req_wdata_i = wd;
    req_valid_i = 1'b1;
    chk(req_ready_o == 1'b1, "R11", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (is_bad(sz, a)) begin
      chk(rsp_valid_o && rsp_err_o, "R9", {30'd0, rsp_valid_o, rsp_err_o}, 32'd3);
      chk(!ext_valid_o && ext_strb_no == 4'hF, "R9", {27'd0, ext_valid_o, ext_strb_no}, 32'hF);
      @(negedge clk_i);
      chk(!ext_valid_o && req_ready_o, "R9", {30'd0, ext_valid_o, req_ready_o}, 32'd1);
      return;
    end
    nb = 1 << sz; wb = bus_bytes(bw); bb = nb < wb ? nb : wb; nbeats = nb / bb;
    for (int k = 0; k < nbeats; k++) begin
      int waits = zero_wait ? 0 : int'($urandom % 3);
      logic [31:0] rd;
      exp_beat(bw, sz, a, wd, k, es, el, ea);
      chk(ext_valid_o && !rsp_valid_o, "R6", {30'd0, ext_valid_o, rsp_valid_o}, 32'd2);
      chk(!req_ready_o, "R11", 32'(req_ready_o), 32'd0);
      chk(ext_addr_o == ea, "R7", ext_addr_o, ea);
      chk(ext_strb_no == es, lane_tag(bw, sz), 32'(ext_strb_no), 32'(es));
      chk(ext_write_o == wr, "R11", 32'(ext_write_o), 32'(wr));
      if (wr) chk(ext_wdata_o == el, "R1", ext_wdata_o, el);
      else    chk(ext_wdata_o == '0, "R10", ext_wdata_o, 32'd0);
      for (int w = 0; w < waits; w++) begin
        @(negedge clk_i);
        chk(ext_valid_o && ext_addr_o == ea && ext_strb_no == es, "R11", ext_addr_o, ea);
      end
      rd = $urandom;
      ext_rdata_i = rd; ext_ready_i = 1'b1;
      for (int j = 0; j < bb; j++) begin
        int i = k * bb + j;
        int ln = wb - 1 - ((int'(a[1:0]) + i) % wb);
        exp_rd[(nb-1-i)*8 +: 8] = rd[ln*8 +: 8];
      end
      @(negedge clk_i);
      ext_ready_i = 1'b0; ext_rdata_i = $urandom;
    end
    chk(rsp_valid_o && !rsp_err_o && !ext_valid_o, "R6",
        {29'd0, rsp_valid_o, rsp_err_o, ext_valid_o}, 32'd4);
    chk(ext_strb_no == 4'hF, "R10", 32'(ext_strb_no), 32'hF);
    if (wr) chk(rsp_rdata_o == '0, "R8", rsp_rdata_o, 32'd0);
    else    chk(rsp_rdata_o == exp_rd, "R8", rsp_rdata_o, exp_rd);
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R8", {30'd0, rsp_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !ext_valid_o && !rsp_valid_o, "R11",
        {29'd0, req_ready_o, ext_valid_o, rsp_valid_o}, 32'd4);
    chk(ext_strb_no == 4'hF, "R10", 32'(ext_strb_no), 32'hF);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed sweep: every width, size, offset, direction
    for (int bw = 0; bw < 4; bw++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int wr = 0; wr < 2; wr++)
            run_access(wr[0], sz[1:0], 32'h1000_0100 + 32'(off), 32'h8A3C_5EF1, bw[1:0], (off + wr) % 2 == 0);
    // longword through an 8-bit bus, zero wait, known pattern (R1, R7)
    run_access(1'b1, 2'd2, 32'h0000_0FF0, 32'h1122_3344, 2'd0, 1'b1);
    run_access(1'b0, 2'd2, 32'hFFFF_FFFC, 32'h0, 2'd1, 1'b1);
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  sz = 2'($urandom % 4);
      logic [31:0] a  = $urandom;
      if ($urandom % 8 != 0) begin
        if (sz == 2'd1) a[0] = 1'b0;
        if (sz == 2'd2) a[1:0] = 2'b00;
        if (sz == 2'd3) sz = 2'($urandom % 3);
      end
      if (sz == 2'd1) a[0] = a[0];
      run_access(1'($urandom), sz, a, $urandom, 2'($urandom % 4), ($urandom % 2) == 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule